// File: doc/BRIEF.md
# Serial port interrupt latch

This block gathers the interrupt conditions of a high-speed serial port into one status word and drives a single interrupt line. Four conditions arrive as one-cycle pulses and are held until software clears them: a transmit request, a framing error, a break and a receive overrun. Two receive conditions are not held. The receive trigger level and the receive idle timeout are shown in the status word exactly as the FIFO logic drives them at that moment.

Software uses a small register port with byte addresses. The status word sits at 0x08. A held bit is cleared by writing one to its position. The control word sits at 0x0C and holds three group enables: transmit, receive and error. The interrupt line is the registered OR of every pending condition whose group is enabled.

Top module: `sport_irq_ctl`

## Requirements
- R1: After reset every held status bit is 0, all three enables are 0 and `irq_o` is 0.
- R2: A pulse on `tx_evt_i`, `frm_err_i`, `brk_i` or `ovr_i` sets status bit 0, 3, 4 or 5 respectively, visible from the clock edge that samples the pulse, and the bit stays set until it is cleared.
- R3: A write to address 0x08 with a one in bit 0, 3, 4 or 5 clears that held bit. Each bit clears independently of the others, and a zero in the write data leaves the bit unchanged.
- R4: When a condition pulses in the same cycle as a write-one that clears it, the bit stays set.
- R5: Status bit 1 always equals `rx_trig_i` and status bit 2 always equals `rx_tmo_i`. Writes to the status word do not change them.
- R6: A write to 0x08 with bit 6 set raises held bit 0, the transmit request, as if `tx_evt_i` had pulsed. Status bit 6 and bits 7 and above read as 0.
- R7: A write to 0x0C stores bit 5 as the transmit enable, bit 6 as the receive enable and bit 7 as the error enable. A read of 0x0C returns those three bits in place, with every other bit 0.
- R8: `irq_o` goes high one clock after any of these is true, and low one clock after none is true: bit 0 with the transmit enable set; bit 1 or 2 with the receive enable set; bit 3, 4 or 5 with the error enable set.
- R9: A read of any address other than 0x08 and 0x0C returns 0. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_evt_i | input | 1 | Transmit request pulse |
| frm_err_i | input | 1 | Framing error pulse |
| brk_i | input | 1 | Break received pulse |
| ovr_i | input | 1 | Receive overrun pulse |
| rx_trig_i | input | 1 | Receive FIFO at trigger level (live) |
| rx_tmo_i | input | 1 | Receive idle timeout (live) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write byte address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Read byte address |
| rd_data_o | output | DATA_W | Read data, combinational from state |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench first drives directed cases. These include a lone pulse on each condition, a write-one clear per bit, a clear that carries zeros elsewhere, an event that collides with its own clear, a software set through bit 6, and each enable alone. These show that bit positions are decoded separately and that set wins over clear. After that comes a long random mix of pulses, level changes, writes to the status word, the control word and unmapped addresses, and reads of all three. This mix exposes cross-talk between groups and off-by-one timing on `irq_o`.

// File: rtl/sport_irq_pkg.sv
package sport_irq_pkg;
  localparam int unsigned N_EVT = 4;
  // status bit positions of the held conditions: tx, framing, break, overrun
  localparam int unsigned EVT_BIT [N_EVT] = '{0, 3, 4, 5};
  localparam int unsigned IDX_TX  = 0;
  localparam int unsigned IDX_FRM = 1;
  localparam int unsigned IDX_BRK = 2;
  localparam int unsigned IDX_OVR = 3;
  localparam int unsigned BIT_RX_TRIG = 1;
  localparam int unsigned BIT_RX_TMO  = 2;
  localparam int unsigned BIT_TX_SET  = 6;
  localparam int unsigned BIT_EN_TX   = 5;
  localparam int unsigned BIT_EN_RX   = 6;
  localparam int unsigned BIT_EN_ERR  = 7;
  localparam int unsigned OFS_STAT = 8'h08;
  localparam int unsigned OFS_CTRL = 8'h0C;

  typedef struct packed {
    logic err;
    logic rx;
    logic tx;
  } grp_en_t;
endpackage

// File: rtl/sport_evt_latch.sv
module sport_evt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;
  logic q_ce;

  always_comb begin
    q_ce = evt_i | clr_i;
    q_d  = evt_i ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= 1'b0;
    else if (q_ce) q_o <= q_d;
  end

  // R2
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> q_o);
  // R3
  clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt_i) |=> !q_o);
  // R3
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !evt_i) |=> $stable(q_o));
endmodule

// File: rtl/sport_ctrl_reg.sv
module sport_ctrl_reg
  import sport_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output grp_en_t           en_o
);
  grp_en_t en_d;

  always_comb begin
    en_d.tx  = wr_data_i[BIT_EN_TX];
    en_d.rx  = wr_data_i[BIT_EN_RX];
    en_d.err = wr_data_i[BIT_EN_ERR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_o <= '0;
    else if (wr_hit_i) en_o <= en_d;
  end

  // R9
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit_i |=> $stable(en_o));
endmodule

// File: rtl/sport_irq_gate.sv
module sport_irq_gate
  import sport_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pend_tx_i,
  input  logic    pend_rx_i,
  input  logic    pend_err_i,
  input  grp_en_t en_i,
  output logic    irq_o
);
  logic irq_d;

  always_comb begin
    irq_d = (pend_tx_i  & en_i.tx)
          | (pend_rx_i  & en_i.rx)
          | (pend_err_i & en_i.err);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_d;
  end

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |=> !irq_o);
  // R8
  irq_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_rx_i && en_i.rx) |=> irq_o);
  // R8
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_tx_i && !pend_rx_i && !pend_err_i) |=> !irq_o);
endmodule

// File: rtl/sport_irq_ctl.sv
module sport_irq_ctl
  import sport_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_evt_i,
  input  logic              frm_err_i,
  input  logic              brk_i,
  input  logic              ovr_i,
  input  logic              rx_trig_i,
  input  logic              rx_tmo_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

  logic             stat_wr;
  logic             ctrl_wr;
  logic             sw_set;
  logic [N_EVT-1:0] evt;
  logic [N_EVT-1:0] clr;
  logic [N_EVT-1:0] held;
  grp_en_t          en;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] ctrl_word;

  always_comb begin
    stat_wr = wr_en_i && (wr_addr_i == A_STAT);
    ctrl_wr = wr_en_i && (wr_addr_i == A_CTRL);
    sw_set  = stat_wr && wr_data_i[BIT_TX_SET];
    evt[IDX_TX]  = tx_evt_i | sw_set;
    evt[IDX_FRM] = frm_err_i;
    evt[IDX_BRK] = brk_i;
    evt[IDX_OVR] = ovr_i;
  end

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    assign clr[g] = stat_wr && wr_data_i[EVT_BIT[g]];
    sport_evt_latch u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (evt[g]),
      .clr_i (clr[g]),
      .q_o   (held[g])
    );
  end

  sport_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit_i  (ctrl_wr),
    .wr_data_i (wr_data_i),
    .en_o      (en)
  );

  always_comb begin
    stat_word = '0;
    for (int i = 0; i < N_EVT; i++) stat_word[EVT_BIT[i]] = held[i];
    stat_word[BIT_RX_TRIG] = rx_trig_i;
    stat_word[BIT_RX_TMO]  = rx_tmo_i;
    ctrl_word = '0;
    ctrl_word[BIT_EN_TX]  = en.tx;
    ctrl_word[BIT_EN_RX]  = en.rx;
    ctrl_word[BIT_EN_ERR] = en.err;
    if (rd_addr_i == A_STAT)      rd_data_o = stat_word;
    else if (rd_addr_i == A_CTRL) rd_data_o = ctrl_word;
    else                          rd_data_o = '0;
  end

  sport_irq_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_tx_i  (held[IDX_TX]),
    .pend_rx_i  (rx_trig_i | rx_tmo_i),
    .pend_err_i (held[IDX_FRM] | held[IDX_BRK] | held[IDX_OVR]),
    .en_i       (en),
    .irq_o      (irq_o)
  );

  // R5
  rx_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == A_STAT) |-> (rd_data_o[BIT_RX_TRIG] == rx_trig_i && rd_data_o[BIT_RX_TMO] == rx_tmo_i));
  // R6
  txset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set |=> held[IDX_TX]);
  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i != A_STAT && rd_addr_i != A_CTRL) |-> (rd_data_o == '0));
endmodule

// File: tb/sport_irq_ctl_bench.sv
`timescale 1ns/100ps
module sport_irq_ctl_bench;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_evt, frm, brk, ovr, rx_trig, rx_tmo, wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state: held bits [tx, frm, brk, ovr], enables [tx, rx, err], irq
  logic [3:0] m_held;
  logic [2:0] m_en;
  logic       m_irq;

  always #2.5 clk = ~clk;

  sport_irq_ctl u_sport_irq_ctl (
    .clk(clk), .rst_n(rst_n), .tx_evt_i(tx_evt), .frm_err_i(frm), .brk_i(brk),
    .ovr_i(ovr), .rx_trig_i(rx_trig), .rx_tmo_i(rx_tmo), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a);
    logic [DW-1:0] v = '0;
    if (a == 5'h08) begin
      v[0] = m_held[0]; v[3] = m_held[1]; v[4] = m_held[2]; v[5] = m_held[3];
      v[1] = rx_trig;   v[2] = rx_tmo;
    end else if (a == 5'h0C) begin
      v[5] = m_en[0]; v[6] = m_en[1]; v[7] = m_en[2];
    end
    return v;
  endfunction

  function automatic logic exp_irq_next();
    return (m_held[0] & m_en[0]) | ((rx_trig | rx_tmo) & m_en[1]) |
           ((m_held[1] | m_held[2] | m_held[3]) & m_en[2]);
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: inputs are already driven; model advances, then compare
  task automatic step(string req);
    logic nirq;
    logic sw, stw;
    logic [3:0] ev, cl;
    nirq = exp_irq_next();
    stw = wr_en && wr_addr == 5'h08;
    sw  = stw && wr_data[6];
    ev  = {ovr, brk, frm, tx_evt | sw};
    cl  = stw ? {wr_data[5], wr_data[4], wr_data[3], wr_data[0]} : 4'b0;
    @(posedge clk);
    #1;
    m_held = ev | (m_held & ~cl);
    if (wr_en && wr_addr == 5'h0C) m_en = {wr_data[7], wr_data[6], wr_data[5]};
    m_irq = nirq;
    check(req, rd_data, exp_read(rd_addr));
    check({req, " irq R8"}, {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic idle();
    tx_evt = 0; frm = 0; brk = 0; ovr = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle(); rx_trig = 0; rx_tmo = 0; rd_addr = 5'h08;
    m_held = '0; m_en = '0; m_irq = 0;
    rst_n = 0;
    #12; rst_n = 1; #1;
    // R1 reset state
    check("R1 status", rd_data, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd_addr = 5'h0C; #1; check("R1 ctrl", rd_data, 32'h0);
    @(negedge clk);
    rd_addr = 5'h08;
    // R2 each pulse sets its bit
    tx_evt = 1; step("R2 tx"); idle();
    frm = 1;    step("R2 frm"); idle();
    brk = 1;    step("R2 brk"); idle();
    ovr = 1;    step("R2 ovr"); idle();
    step("R2 held");
    // R3 zero write no effect, then individual clears
    wr(5'h08, 32'h0); step("R3 zero write"); idle();
    wr(5'h08, 32'h08); step("R3 clear frm only"); idle();
    wr(5'h08, 32'h31); step("R3 clear rest"); idle();
    // R4 collision
    brk = 1; step("R4 set brk"); idle();
    brk = 1; wr(5'h08, 32'h10); step("R4 collide"); idle();
    step("R4 still set");
    // R5 live levels, writes cannot touch them
    rx_trig = 1; wr(5'h08, 32'h06); step("R5 trig"); idle();
    rx_tmo = 1; rx_trig = 0; step("R5 tmo"); idle();
    rx_tmo = 0; step("R5 low");
    // R6 software set
    wr(5'h08, 32'h40); step("R6 set tx"); idle();
    step("R6 bit6 reads 0");
    // R7 enables, R8 irq
    rd_addr = 5'h0C;
    wr(5'h0C, 32'hFFFF_FF20); step("R7 tx en"); idle();
    step("R8 tx irq");
    wr(5'h0C, 32'h80); step("R7 err en"); idle();
    step("R8 err irq");
    wr(5'h0C, 32'h40); step("R7 rx en"); idle();
    rx_trig = 1; step("R8 rx irq"); rx_trig = 0;
    step("R8 rx drop"); step("R8 rx low");
    // R9 unmapped
    rd_addr = 5'h10; wr(5'h10, 32'hFFFF_FFFF); step("R9 unmapped"); idle();
    rd_addr = 5'h0C; step("R9 ctrl kept");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] s;
      tx_evt = ($urandom_range(0, 7) == 0);
      frm    = ($urandom_range(0, 9) == 0);
      brk    = ($urandom_range(0, 9) == 0);
      ovr    = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 5) == 0) rx_trig = ~rx_trig;
      if ($urandom_range(0, 7) == 0) rx_tmo  = ~rx_tmo;
      s = 3'($urandom_range(0, 5));
      wr_en = (s < 3);
      wr_addr = (s == 0) ? 5'h08 : (s == 1) ? 5'h0C : 5'($urandom);
      wr_data = $urandom;
      s = 3'($urandom_range(0, 3));
      rd_addr = (s < 2) ? 5'h08 : (s == 2) ? 5'h0C : 5'($urandom);
      step("R2 R3 R4 R5 R6 R7 R8 R9 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule